// File: doc/BRIEF.md
# Programmable-Flag Word FIFO

A first-in first-out buffer for 9-bit words whose depth is a power of two fixed by a parameter. A producer pushes words with an active-low write enable and a consumer takes them with an active-low read enable. Both ports run on one clock. Five status outputs describe how full the buffer is: a full-side flag, an empty-side flag, a half-full flag, and an almost-full and an almost-empty flag. The almost-full and almost-empty thresholds are programmable, and each can be set to any point in the buffer independently of the other.

The output mode is captured from `ft_mode` while master reset is held low. **Standard mode** releases a word only when the consumer asks for it. **Fall-through mode** presents the oldest word on `rdata` without being asked. In fall-through mode one word sits in the output register, so the usable capacity grows to DEPTH+1 and every level threshold moves up by one word.

Master reset does four things: it clears the contents, empties the output register, restores the default offsets and captures the mode. Partial reset clears the contents and the output register, but it keeps the programmed offsets and the mode.

The output stage is a state machine with three states:
- `ST_STD`: standard mode. The only transition is a self-loop.
- `ST_FT_EMPTY`: fall-through mode with the output register empty.
- `ST_FT_HOLD`: fall-through mode with a word held on `rdata`.

Its transitions are:
- MRST_LOAD: entry into `ST_STD` or `ST_FT_EMPTY`, chosen by `ft_mode` while master reset is held.
- FT_LOAD: `ST_FT_EMPTY` to `ST_FT_HOLD`, taken when the store holds a word.
- FT_KEEP: `ST_FT_HOLD` to itself, taken while no read occurs, or when a read occurs and the store can refill the register.
- FT_DRAIN: `ST_FT_HOLD` to `ST_FT_EMPTY`, taken when a read empties the register and the store is empty.
- PRST: partial reset. `ST_STD` stays in `ST_STD`; either fall-through state goes to `ST_FT_EMPTY`.

Top module: `fifo9_progflag`

## Requirements
- R1: After master reset, `rdata` is 0, `pae_n` is low, `paf_n` and `hf_n` are high. In standard mode `ef_or` is low and `ff_ir` is high. In fall-through mode `ef_or` is high and `ff_ir` is low.
- R2: In standard mode, words leave in the order they were written. A read takes effect on the clock edge where `ren_n` is sampled low, and the word is on `rdata` after that edge.
- R3: In standard mode, `ff_ir` goes low once DEPTH words are held. A write while full is ignored: the stored contents do not change.
- R4: In standard mode, a read while empty is ignored. `rdata` keeps its value, `ef_or` stays low, and the next word written is the next word read.
- R5: In fall-through mode, a word written into an empty FIFO reaches `rdata` one clock edge after its write edge without any read. `ef_or` goes low in the same edge, and a read with `ren_n` low advances to the next word.
- R6: In fall-through mode the capacity is DEPTH+1 words. `ff_ir` goes high when DEPTH+1 words are held, and writes while it is high are ignored.
- R7: Let the effective level be the word count in standard mode and the word count minus one in fall-through mode. `paf_n` is low exactly when the effective level is at least DEPTH − `af_ofs`.
- R8: `pae_n` is low exactly when the effective level is at most `ae_ofs`.
- R9: `hf_n` is low exactly when the effective level is at least DEPTH/2 + 1.
- R10: A high `ofs_ld` loads `ae_ofs` and `af_ofs` on the clock edge. Master reset restores the defaults (both 2 at the default parameters). Partial reset empties the FIFO but keeps the loaded offsets.
- R11: The mode comes only from `ft_mode` while master reset is held. Changing `ft_mode` at other times, or applying partial reset, does not change the mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for both ports |
| mrst_n | input | 1 | Master reset, active low, synchronous |
| prst_n | input | 1 | Partial reset, active low, synchronous |
| ft_mode | input | 1 | Mode select sampled during master reset: 1 selects fall-through |
| wen_n | input | 1 | Write enable, active low |
| wdata | input | DW | Write word |
| ren_n | input | 1 | Read enable, active low |
| rdata | output | DW | Output register |
| ofs_ld | input | 1 | Load strobe for the two offsets |
| ae_ofs | input | AW | Almost-empty offset |
| af_ofs | input | AW | Almost-full offset |
| ff_ir | output | 1 | Standard mode: low when full. Fall-through mode: high when full |
| ef_or | output | 1 | Standard mode: low when empty. Fall-through mode: low when a word is on `rdata` |
| hf_n | output | 1 | Low when more than half full |
| pae_n | output | 1 | Low when almost empty |
| paf_n | output | 1 | Low when almost full |

## Verification
The assertions run on every cycle and cover the following:
- The counter never passes DEPTH and never pops while at zero.
- A write while full leaves the count unchanged.
- In standard mode, `rdata` holds while the FIFO is empty.
- The mode state never crosses between standard and fall-through without a master reset.
- A loaded fall-through register always moves to the holding state.
- The offsets change only when strobed.

Only the bench scenarios can show the data order. They also check each flag threshold against the count at every step of a fill and a drain in both modes, including the one-word shift in fall-through mode. Finally, they show that partial reset keeps the offsets and the mode while master reset restores the defaults.

// File: rtl/fifo9_pkg.sv
package fifo9_pkg;
    typedef enum logic [1:0] {
        ST_STD      = 2'd0,
        ST_FT_EMPTY = 2'd1,
        ST_FT_HOLD  = 2'd2
    } ostate_t;
endpackage

// File: rtl/fifo9_store.sv
module fifo9_store #(
    parameter int DW = 9,
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          clr,
    input  logic          push,
    input  logic [DW-1:0] din,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic [AW:0]   level
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic [AW:0]   cnt;

    always_ff @(posedge clk) begin
        if (clr) begin
            wptr <= '0;
            rptr <= '0;
            cnt  <= '0;
        end else begin
            if (push) wptr <= wptr + AW'(1);
            if (pop)  rptr <= rptr + AW'(1);
            cnt <= cnt + (AW+1)'(push) - (AW+1)'(pop);
        end
    end

    always_ff @(posedge clk) begin
        if (push) mem[wptr] <= din;
    end

    assign head  = mem[rptr];
    assign level = cnt;

    // R3: the counter never passes the storage depth
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (clr)
        cnt <= (AW+1)'(DEPTH));
    // R4: nothing is taken from an empty store
    a_r4_no_underflow: assert property (@(posedge clk) disable iff (clr)
        pop |-> cnt != '0);
    // R2: a lone push raises the count by one
    a_r2_count_up: assert property (@(posedge clk) disable iff (clr)
        (push && !pop) |=> cnt == $past(cnt) + (AW+1)'(1));
endmodule

// File: rtl/fifo9_outstage.sv
module fifo9_outstage
    import fifo9_pkg::*;
#(
    parameter int DW = 9
) (
    input  logic          clk,
    input  logic          mrst_n,
    input  logic          prst_n,
    input  logic          ft_mode,
    input  logic          ren_n,
    input  logic          mem_has,
    input  logic [DW-1:0] head,
    output logic          take,
    output logic          ft,
    output logic          hold,
    output logic [DW-1:0] dout
);
    ostate_t state, nxt;

    always_ff @(posedge clk) begin
        if (!mrst_n)
            state <= ft_mode ? ST_FT_EMPTY : ST_STD;
        else if (!prst_n)
            state <= (state == ST_STD) ? ST_STD : ST_FT_EMPTY;
        else
            state <= nxt;
    end

    always_comb begin
        nxt  = state;
        take = 1'b0;
        unique case (state)
            ST_STD: begin
                take = !ren_n && mem_has;
            end
            ST_FT_EMPTY: begin
                take = mem_has;
                if (mem_has) nxt = ST_FT_HOLD;
            end
            ST_FT_HOLD: begin
                take = !ren_n && mem_has;
                if (!ren_n && !mem_has) nxt = ST_FT_EMPTY;
            end
            default: nxt = ST_STD;
        endcase
    end

    assign ft   = (state != ST_STD);
    assign hold = (state == ST_FT_HOLD);

    always_ff @(posedge clk) begin
        if (!mrst_n || !prst_n) dout <= '0;
        else if (take)          dout <= head;
    end

    // R11: standard mode persists without master reset
    a_r11_std_kept: assert property (@(posedge clk) disable iff (!mrst_n)
        state == ST_STD |=> state == ST_STD);
    // R11: fall-through mode persists without master reset
    a_r11_ft_kept: assert property (@(posedge clk) disable iff (!mrst_n)
        state != ST_STD |=> state != ST_STD);
    // R4: an empty standard-mode read leaves the output register alone
    a_r4_empty_read_hold: assert property (@(posedge clk) disable iff (!mrst_n || !prst_n)
        (state == ST_STD && !mem_has) |=> $stable(dout));
    // R5: a waiting word is always loaded into the output register
    a_r5_fall_through_load: assert property (@(posedge clk) disable iff (!mrst_n || !prst_n)
        (state == ST_FT_EMPTY && mem_has) |=> state == ST_FT_HOLD);
endmodule

// File: rtl/fifo9_flags.sv
module fifo9_flags #(
    parameter int AW     = 4,
    parameter int DEF_AE = 2,
    parameter int DEF_AF = 2
) (
    input  logic          clk,
    input  logic          mrst_n,
    input  logic          ofs_ld,
    input  logic [AW-1:0] ae_in,
    input  logic [AW-1:0] af_in,
    input  logic          ft,
    input  logic          hold,
    input  logic [AW:0]   level,
    output logic          full,
    output logic          ff_ir,
    output logic          ef_or,
    output logic          hf_n,
    output logic          pae_n,
    output logic          paf_n
);
    localparam int DEPTH = 1 << AW;
    localparam logic [AW:0] FULLV   = (AW+1)'(DEPTH);
    localparam logic [AW:0] HALF_UP = (AW+1)'(DEPTH/2 + 1);

    logic [AW-1:0] ae_q, af_q;
    logic [AW:0]   lvl;

    always_ff @(posedge clk) begin
        if (!mrst_n) begin
            ae_q <= AW'(DEF_AE);
            af_q <= AW'(DEF_AF);
        end else if (ofs_ld) begin
            ae_q <= ae_in;
            af_q <= af_in;
        end
    end

    // effective level: one word less in fall-through mode (output register)
    assign lvl   = ft ? (hold ? level : '0) : level;
    assign full  = (lvl == FULLV);
    assign ff_ir = ft ? full : !full;
    assign ef_or = ft ? !hold : (level == '0 ? 1'b0 : 1'b1);
    assign hf_n  = !(lvl >= HALF_UP);
    assign pae_n = !(lvl <= {1'b0, ae_q});
    assign paf_n = !(lvl >= FULLV - {1'b0, af_q});

    // R7: a full buffer is always reported almost full
    a_r7_full_almost_full: assert property (@(posedge clk) disable iff (!mrst_n)
        full |-> !paf_n);
    // R10: offsets move only on the load strobe
    a_r10_offset_kept: assert property (@(posedge clk) disable iff (!mrst_n)
        !ofs_ld |=> ($stable(ae_q) && $stable(af_q)));
endmodule

// File: rtl/fifo9_progflag.sv
module fifo9_progflag #(
    parameter int DW     = 9,
    parameter int AW     = 4,
    parameter int DEF_AE = 2,
    parameter int DEF_AF = 2
) (
    input  logic          clk,
    input  logic          mrst_n,
    input  logic          prst_n,
    input  logic          ft_mode,
    input  logic          wen_n,
    input  logic [DW-1:0] wdata,
    input  logic          ren_n,
    output logic [DW-1:0] rdata,
    input  logic          ofs_ld,
    input  logic [AW-1:0] ae_ofs,
    input  logic [AW-1:0] af_ofs,
    output logic          ff_ir,
    output logic          ef_or,
    output logic          hf_n,
    output logic          pae_n,
    output logic          paf_n
);
    logic          clr, push, take, ft, hold, full;
    logic [DW-1:0] head;
    logic [AW:0]   level;

    assign clr  = !mrst_n || !prst_n;
    assign push = !wen_n && !full;

    fifo9_store #(.DW(DW), .AW(AW)) u_store (
        .clk(clk), .clr(clr), .push(push), .din(wdata),
        .pop(take), .head(head), .level(level)
    );

    fifo9_outstage #(.DW(DW)) u_out (
        .clk(clk), .mrst_n(mrst_n), .prst_n(prst_n), .ft_mode(ft_mode),
        .ren_n(ren_n), .mem_has(level != '0), .head(head),
        .take(take), .ft(ft), .hold(hold), .dout(rdata)
    );

    fifo9_flags #(.AW(AW), .DEF_AE(DEF_AE), .DEF_AF(DEF_AF)) u_flags (
        .clk(clk), .mrst_n(mrst_n), .ofs_ld(ofs_ld), .ae_in(ae_ofs),
        .af_in(af_ofs), .ft(ft), .hold(hold), .level(level),
        .full(full), .ff_ir(ff_ir), .ef_or(ef_or), .hf_n(hf_n),
        .pae_n(pae_n), .paf_n(paf_n)
    );

    // R3 / R6: a write while full does not change the stored count
    a_r3_write_ignored_when_full: assert property (@(posedge clk) disable iff (clr)
        (full && !take) |=> level == $past(level));
endmodule

// File: tb/tb_fifo9_progflag.sv
module tb_fifo9_progflag;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 9;
    localparam int AW = 4;
    localparam int D  = 1 << AW;

    logic clk = 1'b0;
    logic mrst_n = 1'b0, prst_n = 1'b1, ft_mode = 1'b0;
    logic wen_n = 1'b1, ren_n = 1'b1, ofs_ld = 1'b0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic [AW-1:0] ae_ofs = '0, af_ofs = '0;
    logic ff_ir, ef_or, hf_n, pae_n, paf_n;

    int tot = 0, bad = 0;
    int ftm = 0, m_off = 2, n_off = 2;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fifo9_progflag #(.DW(DW), .AW(AW)) dut (
        .clk(clk), .mrst_n(mrst_n), .prst_n(prst_n), .ft_mode(ft_mode),
        .wen_n(wen_n), .wdata(wdata), .ren_n(ren_n), .rdata(rdata),
        .ofs_ld(ofs_ld), .ae_ofs(ae_ofs), .af_ofs(af_ofs),
        .ff_ir(ff_ir), .ef_or(ef_or), .hf_n(hf_n), .pae_n(pae_n), .paf_n(paf_n)
    );

    function automatic logic [DW-1:0] val(input int k, input int salt);
        return DW'(k * 37 + salt * 11 + 5);
    endfunction

    task automatic check_eq(input string tag, input int act, input int exp);
        tot++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic chk_flags(input int e);
        check_eq(ftm ? "R6 ff_ir" : "R3 ff_ir", int'(ff_ir), ftm ? int'(e == D) : int'(e != D));
        check_eq("R7 paf_n", int'(paf_n), int'(!(e >= D - m_off)));
        check_eq("R8 pae_n", int'(pae_n), int'(!(e <= n_off)));
        check_eq("R9 hf_n",  int'(hf_n),  int'(!(e >= D/2 + 1)));
    endtask

    task automatic wr(input logic [DW-1:0] d);
        wen_n = 1'b0; wdata = d;
        @(negedge clk);
        wen_n = 1'b1;
    endtask

    task automatic rd();
        ren_n = 1'b0;
        @(negedge clk);
        ren_n = 1'b1;
    endtask

    task automatic mreset(input int f);
        mrst_n = 1'b0; ft_mode = f[0];
        repeat (2) @(negedge clk);
        mrst_n = 1'b1;
        ftm = f; m_off = 2; n_off = 2;
        @(negedge clk);
        ft_mode = ~f[0];    // R11: ignored outside master reset
    endtask

    task automatic preset();
        prst_n = 1'b0;
        @(negedge clk);
        prst_n = 1'b1;
    endtask

    task automatic t_reset(input int f);
        mreset(f);
        check_eq("R1 rdata", int'(rdata), 0);
        check_eq("R1 ef_or", int'(ef_or), f);
        check_eq("R1 ff_ir", int'(ff_ir), f ? 0 : 1);
        check_eq("R1 pae_n", int'(pae_n), 0);
        check_eq("R1 paf_n", int'(paf_n), 1);
        check_eq("R1 hf_n",  int'(hf_n), 1);
    endtask

    task automatic t_std_fill(input int salt);
        for (int k = 1; k <= D; k++) begin
            wr(val(k, salt));
            chk_flags(k);
            check_eq("R2 ef_or", int'(ef_or), 1);
        end
        wr(9'h1AA);
        check_eq("R3 ff_ir full", int'(ff_ir), 0);
        for (int k = 1; k <= D; k++) begin
            rd();
            check_eq("R2 order", int'(rdata), int'(val(k, salt)));
            chk_flags(D - k);
        end
        check_eq("R4 ef_or empty", int'(ef_or), 0);
        rd();
        check_eq("R4 rdata held", int'(rdata), int'(val(D, salt)));
        check_eq("R4 ef_or stays", int'(ef_or), 0);
        wr(9'h055);
        rd();
        check_eq("R4 next word", int'(rdata), 'h55);
        check_eq("R4 empty again", int'(ef_or), 0);
    endtask

    task automatic t_ft_fill(input int salt);
        wr(val(1, salt));
        check_eq("R5 not ready yet", int'(ef_or), 1);
        @(negedge clk);
        check_eq("R5 ready", int'(ef_or), 0);
        check_eq("R5 fell through", int'(rdata), int'(val(1, salt)));
        chk_flags(0);
        for (int k = 2; k <= D + 1; k++) begin
            wr(val(k, salt));
            chk_flags(k - 1);
        end
        wr(9'h1AA);
        check_eq("R6 still full", int'(ff_ir), 1);
        for (int k = 1; k <= D + 1; k++) begin
            check_eq("R5 head", int'(rdata), int'(val(k, salt)));
            rd();
            chk_flags((D + 1 - k) > 0 ? D - k : 0);
        end
        check_eq("R6 drained", int'(ef_or), 1);
    endtask

    task automatic t_offsets();
        mreset(0);
        ofs_ld = 1'b1; ae_ofs = AW'(5); af_ofs = AW'(3);
        @(negedge clk);
        ofs_ld = 1'b0;
        m_off = 3; n_off = 5;
        for (int k = 1; k <= 4; k++) wr(val(k, 9));
        preset();
        check_eq("R10 prst empties", int'(ef_or), 0);
        check_eq("R10 prst pae", int'(pae_n), 0);
        t_std_fill(3);   // thresholds use the kept offsets
        mreset(0);
        for (int k = 1; k <= 3; k++) begin
            wr(val(k, 4));
            chk_flags(k);   // R10 defaults restored
        end
    endtask

    task automatic t_ft_prst();
        mreset(1);
        for (int k = 1; k <= 5; k++) wr(val(k, 6));
        preset();
        check_eq("R10 prst ef_or", int'(ef_or), 1);
        check_eq("R10 prst rdata", int'(rdata), 0);
        wr(9'h0F0);
        @(negedge clk);
        check_eq("R11 mode kept", int'(rdata), 'hF0);
        check_eq("R11 ready", int'(ef_or), 0);
    endtask

    initial begin
        @(negedge clk);
        t_reset(0);
        t_std_fill(1);
        t_reset(1);
        t_ft_fill(2);
        t_offsets();
        t_ft_prst();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", tot, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tot++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", tot, bad);
            $finish;
        end
    end
endmodule